// File: doc/BRIEF.md
# SPI Flash Generic Command Shifter

This block sends one arbitrary single-lane command to a serial flash device and captures everything the device returns on the data-in line. Software fills a small window of transmit byte registers, writes the total number of serial clock bits for the whole transaction, and sets a start bit in the control register. The engine then lowers chip select, runs SPI mode 0 clock cycles, shifts the transmit bytes out MSB first and samples the input line on every rising edge. The most recent received bytes are left in a bank of result registers that software reads afterwards.

The transmit window is read out from its highest-numbered register downwards. The length counts bits, not bytes, and covers transmit and receive together. When the transmit bytes run out, the output line is held low while sampling goes on. A second start bit runs the same transaction as a status-write. Its completion is reported through a maskable interrupt flag.

The serial clock is a fixed division of the system clock, set by a parameter. The host side is a flat register port: a write strobe, an address and write data, with read data returned combinationally.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, chip select is high, SCLK and MOSI are low, the interrupt line is low and every register reads zero.
- R2: Writing a 1 to bit 2 of the control register (offset 0x00) starts a command transfer; bit 2 reads 1 from the next cycle until the transfer ends, then reads 0 by itself.
- R3: Transmit byte i (i = 0..5) is held in bits 7:0 of offset 0x20 + 4*i; the wire carries byte 5 first, then bytes 4 down to 0, each byte MSB first.
- R4: The count register (offset 0x04, bits 7:0) sets the exact number of SCLK rising edges in a transfer; a count of zero produces a chip-select pulse with no SCLK edge.
- R5: After the 48 transmit bits are sent, MOSI stays low for the remaining bits, and MISO is sampled on every rising edge.
- R6: Result register i (i = 0..9) at offset 0x38 + 4*i holds in bits 7:0 the sampled bits 8*i+7 down to 8*i counted back from the last sample (bit 0 of result 0 is the last sample); positions older than the first sample read 0, since the bank is cleared at every start.
- R7: SCLK idles low; chip select falls HALF_DIV clocks before the first rising edge; each SCLK phase lasts HALF_DIV clocks; chip select rises HALF_DIV clocks after the last falling edge (2*HALF_DIV clocks of chip select low for a zero count).
- R8: While a transfer runs, writes to the transmit or count registers and further start writes do not change the bits sent or the number of edges.
- R9: Writing a 1 to bit 5 of the control register starts a status-write transfer with identical shifting; bit 5 reads 1 while it runs; on completion bit 5 of the interrupt status register (0xA8) is set, the interrupt line equals that bit AND bit 5 of the enable register (0xAC), and writing a 1 to status bit 5 clears it.
- R10: If bits 2 and 5 are written together, only a command transfer runs and the interrupt status stays clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| host_wr | input | 1 | Register write strobe |
| host_addr | input | 8 | Register byte offset |
| host_wdata | input | 32 | Register write data |
| host_rdata | output | 32 | Register read data for host_addr |
| spi_cs_n | output | 1 | Flash chip select, active low |
| spi_sclk | output | 1 | Serial clock, idle low |
| spi_mosi | output | 1 | Serial data to flash |
| spi_miso | input | 1 | Serial data from flash |
| irq | output | 1 | Status-write completion interrupt |

## Verification
On every cycle the assertions check that SCLK only toggles inside chip select, that chip select is high whenever the engine is idle, that a rising edge never happens with no bits left, that the busy flag drops only with a done pulse, and that a finished status-write sets the interrupt flag. The bit order on the wire, the low MOSI tail, the reversed placement in the result bank, the edge count, the chip-select margins and the immunity to writes made during a transfer can only be shown by the bench. It compares recorded wire traffic and the result bank against values it computes itself, over random and directed transfers.

// File: rtl/spi_cmd_pkg.sv
`timescale 1ns/1ps
package spi_cmd_pkg;
    localparam int unsigned HOST_AW      = 8;
    localparam int unsigned HOST_DW      = 32;
    localparam int unsigned OFS_CTRL     = 'h00;
    localparam int unsigned OFS_COUNT    = 'h04;
    localparam int unsigned OFS_TX_BASE  = 'h20;
    localparam int unsigned OFS_RX_BASE  = 'h38;
    localparam int unsigned OFS_IRQ_STAT = 'hA8;
    localparam int unsigned OFS_IRQ_EN   = 'hAC;
    localparam int unsigned OFS_STRIDE   = 4;
    localparam int unsigned BIT_GO_CMD   = 2;
    localparam int unsigned BIT_GO_STS   = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_HIGH,
        ST_LOW,
        ST_TRAIL
    } shift_state_e;
endpackage

// File: rtl/spi_cmd_regs.sv
`timescale 1ns/1ps
module spi_cmd_regs
    import spi_cmd_pkg::*;
#(
    parameter int unsigned TX_BYTES = 6,
    parameter int unsigned RX_BYTES = 10,
    parameter int unsigned CNT_W    = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_i,
    input  logic [HOST_AW-1:0]    addr_i,
    input  logic [HOST_DW-1:0]    wdata_i,
    output logic [HOST_DW-1:0]    rdata_o,
    input  logic                  busy_i,
    input  logic                  sts_kind_i,
    input  logic                  done_i,
    input  logic [8*RX_BYTES-1:0] rx_bits_i,
    output logic [8*TX_BYTES-1:0] tx_bits_o,
    output logic [CNT_W-1:0]      bit_cnt_o,
    output logic                  start_o,
    output logic                  start_sts_o,
    output logic                  irq_o
);
    localparam int unsigned TXW = 8 * TX_BYTES;

    typedef struct packed {
        logic [TXW-1:0]   tx;
        logic [CNT_W-1:0] cnt;
        logic             stat;
        logic             en;
    } regs_t;

    regs_t       q, d;
    int unsigned a;
    logic        ctrl_wr;
    logic        unused_wdata;

    assign a            = 32'(addr_i);
    assign ctrl_wr      = wr_i && (a == OFS_CTRL) && !busy_i;
    assign unused_wdata = ^wdata_i;

    always_comb begin
        d = q;
        if (wr_i) begin
            for (int unsigned i = 0; i < TX_BYTES; i++) begin
                if (a == OFS_TX_BASE + OFS_STRIDE * i) d.tx[8*i +: 8] = wdata_i[7:0];
            end
            if (a == OFS_COUNT)                          d.cnt  = wdata_i[CNT_W-1:0];
            if (a == OFS_IRQ_EN)                         d.en   = wdata_i[BIT_GO_STS];
            if (a == OFS_IRQ_STAT && wdata_i[BIT_GO_STS]) d.stat = 1'b0;
        end
        if (done_i && sts_kind_i) d.stat = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign start_o     = ctrl_wr && (wdata_i[BIT_GO_CMD] || wdata_i[BIT_GO_STS]);
    assign start_sts_o = ctrl_wr && wdata_i[BIT_GO_STS] && !wdata_i[BIT_GO_CMD];
    assign tx_bits_o   = q.tx;
    assign bit_cnt_o   = q.cnt;
    assign irq_o       = q.stat && q.en;

    always_comb begin
        rdata_o = '0;
        if (a == OFS_CTRL) begin
            rdata_o[BIT_GO_CMD] = busy_i && !sts_kind_i;
            rdata_o[BIT_GO_STS] = busy_i && sts_kind_i;
        end
        if (a == OFS_COUNT)    rdata_o = HOST_DW'(q.cnt);
        if (a == OFS_IRQ_STAT) rdata_o[BIT_GO_STS] = q.stat;
        if (a == OFS_IRQ_EN)   rdata_o[BIT_GO_STS] = q.en;
        for (int unsigned i = 0; i < TX_BYTES; i++) begin
            if (a == OFS_TX_BASE + OFS_STRIDE * i) rdata_o = HOST_DW'(q.tx[8*i +: 8]);
        end
        for (int unsigned i = 0; i < RX_BYTES; i++) begin
            if (a == OFS_RX_BASE + OFS_STRIDE * i) rdata_o = HOST_DW'(rx_bits_i[8*i +: 8]);
        end
    end

    // R9: a finished status-write always leaves the interrupt flag set
    assert_sts_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && sts_kind_i) |=> q.stat);

    // R10: a combined start never records a status-write
    assert_cmd_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (start_o && wdata_i[BIT_GO_CMD]) |-> !start_sts_o);
endmodule

// File: rtl/spi_cmd_shifter.sv
`timescale 1ns/1ps
module spi_cmd_shifter
    import spi_cmd_pkg::*;
#(
    parameter int unsigned TX_BYTES = 6,
    parameter int unsigned RX_BYTES = 10,
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned HALF_DIV = 2
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start_i,
    input  logic                  start_sts_i,
    input  logic [8*TX_BYTES-1:0] tx_bits_i,
    input  logic [CNT_W-1:0]      bit_cnt_i,
    output logic                  busy_o,
    output logic                  sts_kind_o,
    output logic                  done_o,
    output logic [8*RX_BYTES-1:0] rx_bits_o,
    output logic                  cs_n_o,
    output logic                  sclk_o,
    output logic                  mosi_o,
    input  logic                  miso_i
);
    localparam int unsigned TXW   = 8 * TX_BYTES;
    localparam int unsigned RXW   = 8 * RX_BYTES;
    localparam int unsigned DIV_W = $clog2(HALF_DIV + 1);

    typedef struct packed {
        shift_state_e     st;
        logic [DIV_W-1:0] div;
        logic [CNT_W-1:0] left;
        logic [TXW-1:0]   tx;
        logic [RXW-1:0]   rx;
        logic             sts;
        logic             cs_n;
        logic             sclk;
        logic             done;
    } shift_t;

    shift_t q, d;
    logic   tick;

    assign tick = (q.div == DIV_W'(HALF_DIV - 1));

    always_comb begin
        d      = q;
        d.done = 1'b0;
        d.div  = tick ? '0 : q.div + 1'b1;
        unique case (q.st)
            ST_IDLE: begin
                d.div = '0;
                if (start_i) begin
                    d.st   = ST_LEAD;
                    d.tx   = tx_bits_i;
                    d.left = bit_cnt_i;
                    d.rx   = '0;
                    d.sts  = start_sts_i;
                    d.cs_n = 1'b0;
                end
            end
            ST_LEAD, ST_LOW: begin
                if (tick) begin
                    if (q.st == ST_LEAD && q.left == '0) begin
                        d.st = ST_TRAIL;
                    end else begin
                        d.st   = ST_HIGH;
                        d.sclk = 1'b1;
                        d.rx   = {q.rx[RXW-2:0], miso_i};
                        d.left = q.left - 1'b1;
                    end
                end
            end
            ST_HIGH: begin
                if (tick) begin
                    d.sclk = 1'b0;
                    d.tx   = {q.tx[TXW-2:0], 1'b0};
                    d.st   = (q.left == '0) ? ST_TRAIL : ST_LOW;
                end
            end
            ST_TRAIL: begin
                if (tick) begin
                    d.st   = ST_IDLE;
                    d.cs_n = 1'b1;
                    d.done = 1'b1;
                end
            end
            default: d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.cs_n <= 1'b1;
        end else begin
            q <= d;
        end
    end

    assign busy_o     = (q.st != ST_IDLE);
    assign sts_kind_o = q.sts;
    assign done_o     = q.done;
    assign rx_bits_o  = q.rx;
    assign cs_n_o     = q.cs_n;
    assign sclk_o     = q.sclk;
    assign mosi_o     = !q.cs_n && q.tx[TXW-1];

    // R7: serial clock only runs while chip select is asserted
    assert_sclk_in_cs_R7: assert property (@(posedge clk) disable iff (!rst_n)
        sclk_o |-> !cs_n_o);

    // R7: chip select is released whenever the engine is idle
    assert_cs_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> cs_n_o);

    // R4: a rising edge is only produced while bits remain
    assert_edge_budget_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sclk_o) |-> ($past(q.left) != '0));

    // R2: busy only drops together with the done pulse
    assert_busy_done_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> done_o);

    // R8: between clock ticks the remaining count and transmit shifter hold
    assert_hold_between_ticks_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !tick) |=> ($stable(q.left) && $stable(q.tx)));
endmodule

// File: rtl/spi_cmd_engine.sv
`timescale 1ns/1ps
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int unsigned TX_BYTES = 6,
    parameter int unsigned RX_BYTES = 10,
    parameter int unsigned CNT_W    = 8,
    parameter int unsigned HALF_DIV = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         host_wr,
    input  logic [7:0]   host_addr,
    input  logic [31:0]  host_wdata,
    output logic [31:0]  host_rdata,
    output logic         spi_cs_n,
    output logic         spi_sclk,
    output logic         spi_mosi,
    input  logic         spi_miso,
    output logic         irq
);
    logic [8*TX_BYTES-1:0] tx_bits;
    logic [8*RX_BYTES-1:0] rx_bits;
    logic [CNT_W-1:0]      bit_cnt;
    logic                  start, start_sts, busy, sts_kind, done;

    spi_cmd_regs #(
        .TX_BYTES(TX_BYTES), .RX_BYTES(RX_BYTES), .CNT_W(CNT_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_i(host_wr), .addr_i(host_addr), .wdata_i(host_wdata), .rdata_o(host_rdata),
        .busy_i(busy), .sts_kind_i(sts_kind), .done_i(done), .rx_bits_i(rx_bits),
        .tx_bits_o(tx_bits), .bit_cnt_o(bit_cnt),
        .start_o(start), .start_sts_o(start_sts), .irq_o(irq)
    );

    spi_cmd_shifter #(
        .TX_BYTES(TX_BYTES), .RX_BYTES(RX_BYTES), .CNT_W(CNT_W), .HALF_DIV(HALF_DIV)
    ) u_shift (
        .clk(clk), .rst_n(rst_n),
        .start_i(start), .start_sts_i(start_sts),
        .tx_bits_i(tx_bits), .bit_cnt_i(bit_cnt),
        .busy_o(busy), .sts_kind_o(sts_kind), .done_o(done), .rx_bits_o(rx_bits),
        .cs_n_o(spi_cs_n), .sclk_o(spi_sclk), .mosi_o(spi_mosi), .miso_i(spi_miso)
    );
endmodule

// File: tb/tb_spi_cmd_engine.sv
`timescale 1ns/1ps
module tb_spi_cmd_engine;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 2;
    localparam int HP         = HALF * CLK_PERIOD;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_wr = 1'b0;
    logic [7:0]  host_addr = '0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        spi_cs_n, spi_sclk, spi_mosi, irq;
    logic        spi_miso = 1'b0;

    int  n_checks = 0;
    int  n_fail   = 0;
    int  edges    = 0;
    bit  mosi_seen [256];
    bit  miso_seen [256];
    time t_cs_fall, t_cs_rise, t_first_rise, t_last_fall;

    spi_cmd_engine #(.HALF_DIV(HALF)) dut (
        .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .spi_cs_n(spi_cs_n),
        .spi_sclk(spi_sclk), .spi_mosi(spi_mosi), .spi_miso(spi_miso), .irq(irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Flash model: new random data bit after every falling edge and at select
    always @(negedge spi_sclk or negedge spi_cs_n) spi_miso <= 1'($urandom & 1);

    always @(posedge spi_sclk) begin
        if (edges < 256) begin
            mosi_seen[edges] = spi_mosi;
            miso_seen[edges] = spi_miso;
        end
        if (edges == 0) t_first_rise = $time;
        edges = edges + 1;
    end
    always @(negedge spi_sclk) t_last_fall = $time;
    always @(negedge spi_cs_n) t_cs_fall = $time;
    always @(posedge spi_cs_n) t_cs_rise = $time;

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    endtask

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic host_write(input int addr, input int data);
        @(negedge clk);
        host_wr = 1'b1; host_addr = 8'(addr); host_wdata = 32'(data);
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic host_read(input int addr, output logic [31:0] data);
        @(negedge clk);
        host_addr = 8'(addr);
        #1 data = host_rdata;
    endtask

    task automatic wait_idle();
        logic [31:0] r;
        int guard = 0;
        do begin
            host_read(0, r);
            guard++;
        end while ((r[2] || r[5]) && guard < 5000);
    endtask

    function automatic bit exp_mosi(input logic [47:0] tx, input int k);
        return (k < 48) ? tx[47-k] : 1'b0;
    endfunction

    function automatic logic [7:0] exp_rx(input int i, input int n);
        logic [7:0] v = '0;
        for (int b = 0; b < 8; b++) begin
            int idx = n - 1 - (8*i + b);
            if (idx >= 0) v[b] = miso_seen[idx];
        end
        return v;
    endfunction

    task automatic load(input logic [47:0] tx, input int n);
        for (int i = 0; i < 6; i++) host_write('h20 + 4*i, int'(tx[8*i +: 8]));
        host_write('h04, n);
    endtask

    task automatic check_wire(input logic [47:0] tx, input int n, input string tag);
        logic [31:0] r;
        int bad = 0;
        chk(edges == n, {"R4 edge count ", tag}, edges, n);
        for (int k = 0; k < n; k++) if (mosi_seen[k] != exp_mosi(tx, k)) bad++;
        chk(bad == 0, {"R3 R5 mosi bit mismatches ", tag}, bad, 0);
        bad = 0;
        for (int i = 0; i < 10; i++) begin
            host_read('h38 + 4*i, r);
            if (r != 32'(exp_rx(i, n))) begin
                bad++;
                $display("FAIL R6 result %0d actual=%0h expected=%0h", i, r, exp_rx(i, n));
            end
        end
        chk(bad == 0, {"R6 result bank ", tag}, bad, 0);
        chk(t_cs_rise - t_cs_fall == ((n == 0) ? 2*HP : (2*n + 1)*HP),
            {"R7 chip select width ", tag}, t_cs_rise - t_cs_fall,
            (n == 0) ? 2*HP : (2*n + 1)*HP);
        if (n > 0) begin
            chk(t_first_rise - t_cs_fall == HP, {"R7 lead ", tag}, t_first_rise - t_cs_fall, HP);
            chk(t_cs_rise - t_last_fall == HP, {"R7 trail ", tag}, t_cs_rise - t_last_fall, HP);
        end
    endtask

    task automatic run_xfer(input logic [47:0] tx, input int n, input bit sts, input string tag);
        logic [31:0] r;
        load(tx, n);
        edges = 0;
        host_write('h00, sts ? 'h20 : 'h04);
        host_read('h00, r);
        if (sts) chk(r == 32'h20, {"R9 status busy bit ", tag}, r, 32'h20);
        else     chk(r == 32'h04, {"R2 command busy bit ", tag}, r, 32'h04);
        wait_idle();
        host_read('h00, r);
        chk(r == 0, {"R2 busy clears ", tag}, r, 0);
        check_wire(tx, n, tag);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        report();
    end

    initial begin
        logic [31:0] r;
        int bad;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset values at the ports and in every register
        chk(spi_cs_n && !spi_sclk && !spi_mosi && !irq, "R1 pins after reset",
            {spi_cs_n, spi_sclk, spi_mosi, irq}, 4'b1000);
        bad = 0;
        foreach (mosi_seen[a]) begin
            if (a < 64) begin
                host_read(4*a, r);
                if (r != 0) bad++;
            end
        end
        chk(bad == 0, "R1 registers zero after reset", bad, 0);

        // Directed: identification-style read, 8 out + 24 in
        run_xfer(48'h9F_00_00_00_00_00, 32, 1'b0, "id read");
        // Full window out plus long tail in: MOSI low after bit 48, older samples drop off
        run_xfer(48'hA5_3C_0F_F0_81_7E, 200, 1'b0, "long tail");
        // Zero count: select pulse only
        run_xfer(48'hFF_FF_FF_FF_FF_FF, 0, 1'b0, "zero count");
        // Maximum count
        run_xfer(48'h0B_12_34_56_00_C3, 255, 1'b0, "max count");

        // Random transfers
        for (int t = 0; t < 16; t++) begin
            logic [47:0] tx = {16'($urandom), 32'($urandom)};
            run_xfer(tx, int'($urandom % 121), 1'b0, "random");
        end

        // R8: writes while busy leave the running transfer alone
        begin
            logic [47:0] tx0 = 48'hC0_FF_EE_11_22_33;
            load(tx0, 40);
            edges = 0;
            host_write('h00, 'h04);
            repeat (10) @(negedge clk);
            for (int i = 0; i < 6; i++) host_write('h20 + 4*i, 'h5A);
            host_write('h04, 7);
            host_write('h00, 'h24);
            wait_idle();
            chk(edges == 40, "R8 edge count kept during busy writes", edges, 40);
            bad = 0;
            for (int k = 0; k < 40; k++) if (mosi_seen[k] != exp_mosi(tx0, k)) bad++;
            chk(bad == 0, "R8 wire bits kept during busy writes", bad, 0);
            repeat (4 * HALF) @(negedge clk);
            chk(spi_cs_n && !spi_sclk, "R8 restart while busy ignored", spi_cs_n, 1);
        end

        // R9: status-write, masked then unmasked, then cleared
        run_xfer(48'h01_00_00_00_00_00, 16, 1'b1, "status write");
        host_read('hA8, r);
        chk(r == 32'h20, "R9 status flag set", r, 32'h20);
        chk(irq == 1'b0, "R9 interrupt masked", irq, 0);
        host_write('hAC, 'h20);
        chk(irq == 1'b1, "R9 interrupt enabled", irq, 1);
        host_write('hA8, 'h20);
        host_read('hA8, r);
        chk(r == 0 && irq == 1'b0, "R9 flag cleared", r, 0);

        // R10: both start bits at once run a command transfer only
        load(48'h05_00_00_00_00_00, 16);
        edges = 0;
        host_write('h00, 'h24);
        host_read('h00, r);
        chk(r == 32'h04, "R10 combined start is a command", r, 32'h04);
        wait_idle();
        host_read('hA8, r);
        chk(r == 0 && irq == 1'b0, "R10 no status flag", r, 0);
        chk(edges == 16, "R10 transfer ran", edges, 16);

        report();
    end
endmodule